// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a peripheral bus clock from the system clock by integer division. Software controls it through a 16-bit synchronous register port. A 7-bit field holds the ratio minus one, so the ratios run from 1 to 128. A field value of zero passes the input clock straight through. An enable bit gates the divided clock. A read-only ready flag reports whether a newly written ratio has reached the running divider.

A new ratio is not applied at once. It is held as pending and ready reads low. The divider takes the pending value only when its current output period ends, and ready then rises again. The enable bit takes effect at the same kind of boundary, so the output never carries a shortened high or low phase. Changes to the ratio field are accepted only while the system unlock input is high and no earlier change is still pending. Writes to the enable bit are always accepted. When a ratio is odd, the high phase is one input cycle shorter than the low phase.

Top module: `pbdiv_top`

## Requirements
- R1: After reset, rd_data reads 16'h8801 (enable bit 15 = 1, ready bit 11 = 1, ratio field bits 6:0 = 1) and clk_out toggles with ratio 2.
- R2: With ratio field F in 1..127, clk_out has a period of F+1 input cycles, with floor((F+1)/2) cycles high followed by ceil((F+1)/2) cycles low.
- R3: With ratio field 0 and enable set, clk_out follows the input clock: high while clk is high and low while clk is low.
- R4: Ready (bit 11) reads 0 from the clock edge that accepts a ratio write. It reads 1 again at the edge where the divider takes the new value.
- R5: A write while unlock is low leaves the ratio field unchanged and ready high, but still updates the enable bit.
- R6: A ratio write while ready is low is ignored; the pending value is the one that gets applied.
- R7: Clearing enable lets the running period finish at full length and then holds clk_out low. Setting it again resumes with full periods.
- R8: A ratio written mid-period is applied only after the current output period ends, so the high phase in progress keeps the old length.
- R9: Bits 6:0 read back the stored ratio field, bit 15 reads the enable and bit 11 reads ready. Bits 14:12 and 10:7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: bit 15 enable, bits 6:0 ratio minus one |
| unlock | input | 1 | System unlock state; high allows ratio field writes |
| rd_data | output | 16 | Register read value |
| clk_out | output | 1 | Divided peripheral bus clock |

## Verification
The bench sweeps every ratio from 2 to 128 and measures the high and low run lengths. A wrong half-period computation would show up as a skewed duty cycle or as an extra or missing cycle on odd ratios. It writes a new ratio just after a rising edge of the output. A divider that loaded the value immediately would cut that high phase short. It also clears enable in the middle of a high phase; gating that was not tied to the period boundary would produce a runt pulse. Writes sent while locked or while a change is pending are checked for silent rejection. A design that let them through would change the readback and the measured period. Pass-through mode is checked on both clock phases.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;
    localparam int DIV_W   = 7;
    localparam int REG_W   = 16;
    localparam int EN_POS  = 15;
    localparam int RDY_POS = 11;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        div_t cnt;
        div_t cur;
        logic en;
        logic phase;
    } div_state_t;

    function automatic logic [DIV_W:0] high_len(input div_t n);
        logic [DIV_W:0] r;
        r = {1'b0, n} + {{DIV_W{1'b0}}, 1'b1};
        return r >> 1;
    endfunction
endpackage

// File: rtl/pbdiv_regs.sv
module pbdiv_regs
    import pbdiv_pkg::*;
#(
    parameter div_t RST_DIV = div_t'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             unlock,
    input  logic             load_done,
    output logic             en_req,
    output logic             pend,
    output div_t             field,
    output logic [REG_W-1:0] rd_data
);
    logic div_ok;

    assign div_ok = wr_en && unlock && !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_req <= 1'b1;
            pend   <= 1'b0;
            field  <= RST_DIV;
        end else begin
            if (wr_en)
                en_req <= wr_data[EN_POS];
            if (div_ok) begin
                field <= wr_data[DIV_W-1:0];
                pend  <= 1'b1;
            end else if (load_done) begin
                pend <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data              = '0;
        rd_data[DIV_W-1:0]   = field;
        rd_data[RDY_POS]     = !pend;
        rd_data[EN_POS]      = en_req;
    end
endmodule

// File: rtl/pbdiv_core.sv
module pbdiv_core
    import pbdiv_pkg::*;
#(
    parameter div_t RST_DIV = div_t'(1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_req,
    input  logic       pend,
    input  div_t       new_div,
    output logic       load_done,
    output div_state_t st
);
    div_state_t     st_d;
    logic           wrap;
    logic [DIV_W:0] half_d;

    assign wrap      = (st.cnt == st.cur);
    assign load_done = wrap && pend;

    always_comb begin
        st_d.cnt   = wrap ? '0 : st.cnt + div_t'(1);
        st_d.cur   = load_done ? new_div : st.cur;
        st_d.en    = wrap ? en_req : st.en;
        half_d     = high_len(st_d.cur);
        st_d.phase = st_d.en && ({1'b0, st_d.cnt} < half_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cnt   <= '0;
            st.cur   <= RST_DIV;
            st.en    <= 1'b1;
            st.phase <= 1'b0;
        end else begin
            st <= st_d;
        end
    end
endmodule

// File: rtl/pbdiv_top.sv
module pbdiv_top
    import pbdiv_pkg::*;
#(
    parameter div_t RST_DIV = div_t'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             unlock,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_out
);
    logic       en_req;
    logic       pend;
    logic       load_done;
    div_t       field;
    div_state_t st;
    div_t       st_cnt;
    div_t       st_cur;
    logic       st_en;
    logic       st_phase;
    logic       byp_q;
    logic       gate_q;

    pbdiv_regs #(.RST_DIV(RST_DIV)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .unlock(unlock), .load_done(load_done), .en_req(en_req),
        .pend(pend), .field(field), .rd_data(rd_data)
    );

    pbdiv_core #(.RST_DIV(RST_DIV)) core_i (
        .clk(clk), .rst(rst), .en_req(en_req), .pend(pend),
        .new_div(field), .load_done(load_done), .st(st)
    );

    assign st_cnt   = st.cnt;
    assign st_cur   = st.cur;
    assign st_en    = st.en;
    assign st_phase = st.phase;

    // Bypass select and gate change only while clk is low.
    always_ff @(negedge clk) begin
        if (rst) begin
            byp_q  <= 1'b0;
            gate_q <= 1'b1;
        end else begin
            byp_q  <= (st_cur == '0);
            gate_q <= st_en;
        end
    end

    assign clk_out = byp_q ? (clk && gate_q) : st_phase;
endmodule

// File: rtl/pbdiv_checker.sv
module pbdiv_checker
    import pbdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             unlock,
    input logic [REG_W-1:0] rd_data,
    input div_t             cnt,
    input div_t             cur,
    input logic             phase,
    input logic             en_act
);
    assert_field_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_data[RDY_POS] |=> rd_data[DIV_W-1:0] == $past(rd_data[DIV_W-1:0]));

    assert_locked_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !unlock) |=> rd_data[DIV_W-1:0] == $past(rd_data[DIV_W-1:0]));

    assert_load_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[RDY_POS]) |-> cnt == '0);

    assert_fall_at_half_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(phase) |-> {1'b0, cnt} == high_len(cur));

    assert_rise_at_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(phase) |-> cnt == '0);

    assert_gate_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_act) |-> cnt == '0);
endmodule

bind pbdiv_top pbdiv_checker chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .unlock(unlock), .rd_data(rd_data),
    .cnt(st_cnt), .cur(st_cur), .phase(st_phase), .en_act(st_en)
);

// File: tb/pbdiv_top_tb_top.sv
module pbdiv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        unlock = 1'b0;
    logic [15:0] rd_data;
    logic        clk_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pbdiv_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .unlock(unlock), .rd_data(rd_data), .clk_out(clk_out)
    );

    function automatic logic [15:0] exp_rd(input logic en, input logic rdy, input logic [6:0] f);
        return {en, 3'b000, rdy, 4'b0000, f};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic en, input logic [6:0] f, input logic unl);
        wr_en   = 1'b1;
        wr_data = {en, 8'h00, f};
        unlock  = unl;
        step();
        wr_en   = 1'b0;
        unlock  = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400; i++) begin
            if (rd_data[11] === 1'b1) break;
            step();
        end
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        g = 0;
        while (clk_out !== 1'b0 && g < 600) begin step(); g++; end
        while (clk_out !== 1'b1 && g < 1200) begin step(); g++; end
        hi = 0;
        while (clk_out === 1'b1 && hi < 300) begin hi++; step(); end
        lo = 0;
        while (clk_out === 1'b0 && lo < 300) begin lo++; step(); end
    endtask

    task automatic wait_rise();
        int g;
        g = 0;
        while (clk_out !== 1'b0 && g < 600) begin step(); g++; end
        while (clk_out !== 1'b1 && g < 1200) begin step(); g++; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi, lo;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        step();
        // R1 reset state
        check("R1 reset readback", rd_data, 16'h8801);
        measure(hi, lo);
        check("R1 reset high", hi, 1);
        check("R1 reset low", lo, 1);

        // R2 / R4 / R9 full ratio sweep
        for (int r = 2; r <= 128; r++) begin
            wait_ready();
            reg_write(1'b1, 7'(r - 1), 1'b1);
            check("R4 ready low after write", rd_data[11], 0);
            wait_ready();
            check("R9 readback", rd_data, exp_rd(1'b1, 1'b1, 7'(r - 1)));
            measure(hi, lo);
            check("R2 high run", hi, r / 2);
            check("R2 low run", lo, (r + 1) / 2);
        end

        // R5 locked write: field kept, enable still written
        wait_ready();
        reg_write(1'b1, 7'd5, 1'b0);
        check("R5 locked ready stays high", rd_data[11], 1);
        check("R5 locked field kept", rd_data, exp_rd(1'b1, 1'b1, 7'd127));
        reg_write(1'b0, 7'd5, 1'b0);
        check("R5 enable written while locked", rd_data, exp_rd(1'b0, 1'b1, 7'd127));
        reg_write(1'b1, 7'd5, 1'b0);

        // R6 write while busy ignored
        wait_ready();
        reg_write(1'b1, 7'd63, 1'b1);
        wait_ready();
        reg_write(1'b1, 7'd9, 1'b1);
        reg_write(1'b1, 7'd3, 1'b1);
        check("R6 busy write ignored readback", rd_data, exp_rd(1'b1, 1'b0, 7'd9));
        wait_ready();
        check("R6 applied value", rd_data, exp_rd(1'b1, 1'b1, 7'd9));
        measure(hi, lo);
        check("R6 high run", hi, 5);
        check("R6 low run", lo, 5);

        // R8 mid-period write keeps current high phase
        reg_write(1'b1, 7'd19, 1'b1);
        wait_ready();
        wait_rise();
        hi = 1;
        reg_write(1'b1, 7'd3, 1'b1);
        check("R8 ready low mid-period", rd_data[11], 0);
        while (clk_out === 1'b1 && hi < 300) begin hi++; step(); end
        check("R8 old high kept", hi, 10);
        measure(hi, lo);
        check("R8 new high", hi, 2);
        check("R8 new low", lo, 2);

        // R7 clean stop and resume
        reg_write(1'b1, 7'd15, 1'b1);
        wait_ready();
        wait_rise();
        hi = 1;
        reg_write(1'b0, 7'd0, 1'b0);
        while (clk_out === 1'b1 && hi < 300) begin hi++; step(); end
        check("R7 last high full length", hi, 8);
        lo = 0;
        for (int i = 0; i < 40; i++) begin
            if (clk_out !== 1'b0) lo++;
            step();
        end
        check("R7 output held low", lo, 0);
        reg_write(1'b1, 7'd0, 1'b0);
        measure(hi, lo);
        check("R7 resume high", hi, 8);
        check("R7 resume low", lo, 8);

        // R3 pass-through
        reg_write(1'b1, 7'd0, 1'b1);
        wait_ready();
        step();
        step();
        hi = 0;
        lo = 0;
        for (int i = 0; i < 8; i++) begin
            if (clk_out !== 1'b1) hi++;
            @(negedge clk);
            #1;
            if (clk_out !== 1'b0) lo++;
            step();
        end
        check("R3 follows clk high", hi, 0);
        check("R3 follows clk low", lo, 0);
        check("R9 readback bypass", rd_data, exp_rd(1'b1, 1'b1, 7'd0));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule